// File: doc/BRIEF.md
# SD Card Clock Control

This block derives the card clock of an SD host from a fast base clock and controls when that clock may run. Software first writes the clock-control register with a frequency select value and the internal enable. It then polls a read-only stable flag, which the hardware raises after a fixed settling count. Only after that does software set the card-clock enable. A select value N above zero divides the base clock by 2N, and a select of zero passes the base clock straight through. For example, a 216 MHz base gives about 375 kHz at select 0x120 if the field is widened. At the 8-bit width shown here, select 2 gives 54 MHz.

The same block holds the host-control byte, which sets the data bus width. It also holds a sticky interrupt-status vector and a self-clearing reset-for-all. The reset-for-all clears every register, holds them clear for a fixed number of cycles, and then reports itself done by dropping its busy bit.

Writes use a 2-bit address:

| Address | Register |
|---------|----------|
| 0 | Clock control |
| 1 | Host control |
| 2 | Reset-for-all |
| 3 | Write-one-to-clear of interrupt status |

Top module: `sd_clkctl`

## Requirements
- R1: A write to address 0 stores the select value from data[15:8], the card-clock enable from data[2] and the internal enable from data[0]. The readback `clk_ctl_rd` reads the select at [15:8], the card-clock enable at [2], the stable flag at [1] and the internal enable at [0], with all other bits zero. A 1 written to bit 1 is ignored.
- R2: The stable flag rises on the 16th clock edge after the edge that stored internal enable = 1. It drops on the same edge that stores internal enable = 0.
- R3: `card_clk` stays low while the card-clock enable is 0 or the stable flag is 0. This holds whether the enable was set before or after the stable flag rose, and it holds right after all zeros are written to address 0.
- R4: With a select value N from 1 to 255 and the clock running, `card_clk` has a period of 2N base cycles and is high for N of them.
- R5: With a select value of 0 and the clock running, `card_clk` follows the base clock: high while `clk` is high and low while it is low.
- R6: `bus_width` decodes the host-control byte written at address 1. Bit 5 set gives 2 (8-bit). Otherwise bit 1 set gives 1 (4-bit). Otherwise it gives 0 (1-bit). `host_ctl_rd` reads the byte back.
- R7: Writing 1 to data[0] at address 2 raises `srst_busy` for exactly 8 cycles. In the same edge it clears the clock-control, host-control and interrupt-status registers, which stay zero while busy. `srst_busy` then clears by itself.
- R8: While `srst_busy` is high, register writes and `irq_set` pulses have no effect.
- R9: Each `irq_set` bit sets the matching `int_status` bit, and that bit holds until a write to address 3 with 1 in that data bit clears it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address (0 clock, 1 host, 2 reset, 3 status clear) |
| wr_data | input | 16 | Write data |
| irq_set | input | IRQ_W | Interrupt event pulses |
| clk_ctl_rd | output | 16 | Clock-control readback |
| host_ctl_rd | output | 8 | Host-control readback |
| int_status | output | IRQ_W | Sticky interrupt status |
| srst_busy | output | 1 | Reset-for-all in progress (reads back as the reset bit) |
| bus_width | output | 2 | Decoded bus width: 0 is 1-bit, 1 is 4-bit, 2 is 8-bit |
| card_clk | output | 1 | Gated and divided card clock |

## Verification
The assertions assume that write strobes and `irq_set` change only away from the rising edge. They also assume that `wr_addr` carries one of the four decoded values whenever `wr_en` is high. The interrupt-status assertion further assumes that no status-clear write lands in the same cycle as the event it watches. The bench drives every input half a cycle after the falling edge and pulses interrupts only in cycles with no write, so the stimulus stays inside these assumptions. The divider sweep covers the low select values fully, plus two large ones, and measures the high and low phase lengths at the ports. The host-control byte is swept over all 256 values.

// File: rtl/sd_clkctl.sv
module sd_clkctl #(
  parameter int STABLE_CYCLES = 16,
  parameter int RESET_CYCLES  = 8,
  parameter int IRQ_W         = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [15:0]      wr_data,
  input  logic [IRQ_W-1:0] irq_set,
  output logic [15:0]      clk_ctl_rd,
  output logic [7:0]       host_ctl_rd,
  output logic [IRQ_W-1:0] int_status,
  output logic             srst_busy,
  output logic [1:0]       bus_width,
  output logic             card_clk
);
  localparam int STW = $clog2(STABLE_CYCLES + 1);
  localparam int RTW = $clog2(RESET_CYCLES);
  localparam logic [1:0] A_CLK = 2'd0, A_HOST = 2'd1, A_SRST = 2'd2, A_IRQ = 2'd3;

  logic [7:0]       sel_q;
  logic             ien_q, sden_q;
  logic [STW-1:0]   st_cnt;
  logic [7:0]       host_q;
  logic [IRQ_W-1:0] irq_q;
  logic             busy_q;
  logic [RTW-1:0]   rcnt;
  logic [7:0]       div_cnt;
  logic             div_q, gate_n;

  wire stable = ien_q && (st_cnt == STW'(STABLE_CYCLES));
  wire run    = sden_q && stable;
  wire bypass = (sel_q == 8'd0);
  wire [IRQ_W-1:0] w1c = (wr_en && wr_addr == A_IRQ) ? wr_data[IRQ_W-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0; ien_q <= 1'b0; sden_q <= 1'b0;
      host_q <= '0; irq_q <= '0; busy_q <= 1'b0; rcnt <= '0;
    end else if (busy_q) begin
      sel_q <= '0; ien_q <= 1'b0; sden_q <= 1'b0;
      host_q <= '0; irq_q <= '0;
      if (rcnt == RTW'(RESET_CYCLES - 1)) busy_q <= 1'b0;
      else rcnt <= rcnt + 1'b1;
    end else if (wr_en && wr_addr == A_SRST && wr_data[0]) begin
      sel_q <= '0; ien_q <= 1'b0; sden_q <= 1'b0;
      host_q <= '0; irq_q <= '0; busy_q <= 1'b1; rcnt <= '0;
    end else begin
      if (wr_en && wr_addr == A_CLK) begin
        sel_q  <= wr_data[15:8];
        sden_q <= wr_data[2];
        ien_q  <= wr_data[0];
      end
      if (wr_en && wr_addr == A_HOST) host_q <= wr_data[7:0];
      irq_q <= (irq_q & ~w1c) | irq_set;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_cnt <= '0;
    else if (!ien_q) st_cnt <= '0;
    else if (!stable) st_cnt <= st_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_cnt <= '0; div_q <= 1'b0;
    end else if (!run || bypass) begin
      div_cnt <= '0; div_q <= 1'b0;
    end else if (div_cnt >= sel_q - 8'd1) begin
      div_cnt <= '0; div_q <= ~div_q;
    end else begin
      div_cnt <= div_cnt + 8'd1;
    end
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) gate_n <= 1'b0;
    else gate_n <= run && bypass;
  end

  assign card_clk    = bypass ? (clk & gate_n) : (div_q & run);
  assign clk_ctl_rd  = {sel_q, 5'b0, sden_q, stable, ien_q};
  assign host_ctl_rd = host_q;
  assign int_status  = irq_q;
  assign srst_busy   = busy_q;
  assign bus_width   = host_q[5] ? 2'd2 : (host_q[1] ? 2'd1 : 2'd0);
endmodule

// File: rtl/sd_clkctl_chk.sv
module sd_clkctl_chk #(
  parameter int STABLE_CYCLES = 16,
  parameter int RESET_CYCLES  = 8,
  parameter int IRQ_W         = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic             irq0,
  input logic [15:0]      clk_ctl_rd,
  input logic [7:0]       host_ctl_rd,
  input logic [IRQ_W-1:0] int_status,
  input logic             srst_busy,
  input logic [1:0]       bus_width,
  input logic             card_clk
);
  localparam int CW = $clog2(STABLE_CYCLES + RESET_CYCLES + 2);
  logic [CW-1:0] en_run, bz_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_run <= '0; bz_run <= '0;
    end else begin
      en_run <= !clk_ctl_rd[0] ? '0 : (en_run == CW'(STABLE_CYCLES + 1) ? en_run : en_run + 1'b1);
      bz_run <= !srst_busy ? '0 : bz_run + 1'b1;
    end
  end

  AST_STABLE_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_ctl_rd[1]) |-> en_run == CW'(STABLE_CYCLES)); // R2
  AST_CARD_CLK_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !(clk_ctl_rd[2] && clk_ctl_rd[1]) |-> !card_clk); // R3
  AST_WIDE8_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    host_ctl_rd[5] |-> bus_width == 2'd2); // R6
  AST_RESET_HOLDS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    srst_busy |-> (clk_ctl_rd == 16'd0 && host_ctl_rd == 8'd0 && int_status == '0)); // R7
  AST_RESET_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(srst_busy) |-> bz_run == CW'(RESET_CYCLES)); // R7
  AST_IRQ_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    (irq0 && !srst_busy && !wr_en) |=> int_status[0]); // R9
endmodule

bind sd_clkctl sd_clkctl_chk #(
  .STABLE_CYCLES(STABLE_CYCLES), .RESET_CYCLES(RESET_CYCLES), .IRQ_W(IRQ_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .irq0(irq_set[0]),
  .clk_ctl_rd(clk_ctl_rd), .host_ctl_rd(host_ctl_rd), .int_status(int_status),
  .srst_busy(srst_busy), .bus_width(bus_width), .card_clk(card_clk)
);

// File: tb/tb_sd_clkctl.sv
module tb_sd_clkctl;
  localparam int PERIOD = 10;
  localparam int IRQ_W = 8;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [IRQ_W-1:0] irq_set = '0;
  logic [15:0] clk_ctl_rd;
  logic [7:0] host_ctl_rd;
  logic [IRQ_W-1:0] int_status;
  logic srst_busy, card_clk;
  logic [1:0] bus_width;

  int vectors = 0, fails = 0;
  bit done = 0;

  always #(PERIOD/2) clk = ~clk;

  sd_clkctl #(.IRQ_W(IRQ_W)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .irq_set(irq_set), .clk_ctl_rd(clk_ctl_rd), .host_ctl_rd(host_ctl_rd),
    .int_status(int_status), .srst_busy(srst_busy), .bus_width(bus_width),
    .card_clk(card_clk));

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    step(); wr_en = 1'b1; wr_addr = a; wr_data = d;
    step(); wr_en = 1'b0;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_stable();
    for (int i = 0; i < 40 && !clk_ctl_rd[1]; i++) step();
  endtask

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    step(); step();
    chk("reset clk_ctl", clk_ctl_rd, 0);
    chk("reset card_clk", card_clk, 0);
    chk("reset busy", srst_busy, 0);
    rst_n = 1'b1;
    step();

    // R1 field layout, bit 1 ignored on write
    wr(2'd0, 16'hAB07);
    chk("R1 readback before stable", clk_ctl_rd, 16'hAB05);
    wait_stable();
    chk("R1 readback after stable", clk_ctl_rd, 16'hAB07);
    wr(2'd0, 16'h0000);
    chk("R3 zeros stop clock", card_clk, 0);
    chk("R2 zeros drop stable", clk_ctl_rd, 0);

    // R2 exact settle count
    wr(2'd0, 16'h0201);
    for (int m = 0; m <= 20; m++) begin
      chk($sformatf("R2 stable at m=%0d", m), clk_ctl_rd[1], m >= 16);
      step();
    end
    wr(2'd0, 16'h0200);
    chk("R2 stable clears at once", clk_ctl_rd[1], 0);

    // R3 card clock held low before stable even with enable set
    wr(2'd0, 16'h0105);
    for (int m = 0; m <= 16; m++) begin
      chk($sformatf("R3 low before stable m=%0d", m), card_clk, 0);
      step();
    end
    wr(2'd0, 16'h0000);
    wr(2'd0, 16'h0101);
    wait_stable();
    for (int m = 0; m < 12; m++) begin
      chk("R3 low with enable clear", card_clk, 0);
      step();
    end

    // R4 divider sweep
    for (int n = 1; n <= 14; n++) begin
      automatic int nv = (n <= 12) ? n : ((n == 13) ? 100 : 255);
      automatic int hi = 0, lo = 0;
      wr(2'd0, 16'h0000);
      wr(2'd0, 16'(nv << 8) | 16'h0001);
      wait_stable();
      wr(2'd0, 16'(nv << 8) | 16'h0005);
      for (int i = 0; i < 600 && !card_clk; i++) step();
      for (int i = 0; i < 600 && card_clk; i++) begin hi++; step(); end
      for (int i = 0; i < 600 && !card_clk; i++) begin lo++; step(); end
      chk($sformatf("R4 high phase N=%0d", nv), hi, nv);
      chk($sformatf("R4 low phase N=%0d", nv), lo, nv);
    end

    // R5 bypass follows base clock
    wr(2'd0, 16'h0000);
    wr(2'd0, 16'h0001);
    wait_stable();
    wr(2'd0, 16'h0005);
    step(); step();
    for (int i = 0; i < 8; i++) begin
      @(posedge clk); #1;
      chk("R5 high with base high", card_clk, 1);
      @(negedge clk); #1;
      chk("R5 low with base low", card_clk, 0);
    end
    wr(2'd0, 16'h0000);
    chk("R3 bypass stops", card_clk, 0);

    // R6 exhaustive host byte
    for (int v = 0; v < 256; v++) begin
      wr(2'd1, 16'(v));
      chk($sformatf("R6 width for %0d", v), bus_width, v[5] ? 2 : (v[1] ? 1 : 0));
      chk("R6 readback", host_ctl_rd, v);
    end

    // R9 sticky status and clear
    step(); irq_set = 8'h81; step(); irq_set = '0;
    chk("R9 set", int_status, 8'h81);
    step(); step();
    chk("R9 holds", int_status, 8'h81);
    wr(2'd3, 16'h0001);
    chk("R9 clear bit 0", int_status, 8'h80);

    // R7 reset-for-all
    wr(2'd0, 16'h0401);
    wr(2'd1, 16'h0022);
    wr(2'd2, 16'h0001);
    for (int m = 0; m <= 10; m++) begin
      chk($sformatf("R7 busy m=%0d", m), srst_busy, m < 8);
      if (m < 8) begin
        chk("R7 clk_ctl cleared", clk_ctl_rd, 0);
        chk("R7 host cleared", host_ctl_rd, 0);
        chk("R7 status cleared", int_status, 0);
      end
      step();
    end

    // R8 writes and events ignored while busy
    wr(2'd2, 16'h0001);
    wr(2'd1, 16'h0022);
    wr(2'd0, 16'h0301);
    step(); irq_set = 8'h0F; step(); irq_set = '0;
    for (int i = 0; i < 10; i++) step();
    chk("R8 busy done", srst_busy, 0);
    chk("R8 host untouched", host_ctl_rd, 0);
    chk("R8 clk_ctl untouched", clk_ctl_rd, 0);
    chk("R8 status untouched", int_status, 0);
    chk("R8 width", bus_width, 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule